// File: doc/BRIEF.md
# Two-Stage Interrupt Controller With Fast Routing

This block collects up to 32 interrupt sources and presents two active-low request lines to a processor. Each source can be a level or a pulse. An asserted source is first captured in a raw pending register. A per-bit routing register sends each captured source to one of two places:

- the fast request line, or
- the normal path, where a per-bit mask can block it.

On the normal path a fixed-priority picker selects one unmasked, normally routed source. That winner is held as a single set bit in a second pending register. The winner register is loaded only while it is empty, so a request that is already being serviced is never replaced.

Software uses a small register file on a 32-bit bus. It reads the raw pending register, the routing register, the mask, the winner register and the index of the winner. After servicing a source, it clears the source's bit in both pending registers by writing ones to them.

Top module: `irq_two_stage_ctrl`

## Requirements
- R1: When a source input is high at a clock edge, its bit in the raw pending register (offset 0x00) is 1 after that edge. This holds whatever the routing and mask bits are.
- R2: A routing bit of 1 (register at offset 0x04, reset 0) steers its source to the fast line. `fiq_n` is low exactly while some raw pending bit with routing bit 1 is set. A fast-routed source never enters the winner register.
- R3: A mask bit of 1 (register at offset 0x08, reset all ones) keeps its source out of the winner register. The source's raw pending bit stays set.
- R4: The winner register (offset 0x10) has at most one bit set. When it loads, it takes the lowest-indexed source that is raw pending, routed normal (routing bit 0) and unmasked (mask bit 0). Bit 0 has the highest priority.
- R5: The winner register loads only on an edge at which it was empty. The new winner is visible one edge after the raw pending bit. A later request with higher priority does not replace a winner that is held.
- R6: Writing to offset 0x00 or 0x10 clears every bit written as 1 and leaves bits written as 0 unchanged. If a source sets a raw pending bit in the same cycle that a write clears it, the bit ends up set.
- R7: `irq_n` is low exactly while the winner register is non-zero. Both request lines are high after reset.
- R8: Offset 0x14 reads the 5-bit index of the winner in bits 4:0, and reads 0 when the winner register is empty. Writes to offset 0x14 have no effect.
- R9: After reset, all registers read 0 except the mask, which reads 0xFFFFFFFF. An unmapped offset, or any read with `bus_sel` low, returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_src | input | 32 | Interrupt source lines, active high |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the offset |
| irq_n | output | 1 | Normal request, active low |
| fiq_n | output | 1 | Fast request, active low |

## Verification
A source sampled at edge k appears in the raw pending register and on `fiq_n` right after edge k. It reaches the winner register, the index and `irq_n` right after edge k+1, provided the winner register was empty at edge k+1. A clearing or configuration write takes effect at the edge that samples it. The bench drives each stimulus at the falling edge. It samples 1 ns after the next rising edge, using a bench model that is stepped on the same edge. The directed checks count out these one-edge and two-edge delays explicitly, for example for the no-preemption and same-cycle set/clear cases.

// File: rtl/intc_pkg.sv
// Shared constants for the two-stage interrupt controller: bus widths and
// register offsets. Offsets are byte addresses on a word-wide bus.
package intc_pkg;
    localparam int ADDR_W = 5;
    localparam int BUS_W  = 32;

    localparam logic [ADDR_W-1:0] OFS_RAW    = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_ROUTE  = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_WIN    = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_WINIDX = 5'h14;
endpackage

// File: rtl/irq_raw_latch.sv
// Raw pending latch: one sticky bit per source.
// Assumes set_i is sampled every edge; a set beats a clear on the same bit.
module irq_raw_latch #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    // Capture new requests, drop bits cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_o <= '0;
        else        pend_o <= (pend_o & ~clr_i) | set_i;
    end
endmodule

// File: rtl/irq_prio_pick.sv
// Fixed-priority picker: lowest set index wins.
// Outputs a one-hot grant and the index of the winning bit. Purely combinational.
module irq_prio_pick #(
    parameter int N  = 32,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    output logic [N-1:0]  grant_o,
    output logic [IW-1:0] idx_o
);
    // Scan from the top down, so the lowest set bit is written last and wins.
    always_comb begin
        grant_o = '0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                grant_o    = '0;
                grant_o[i] = 1'b1;
                idx_o      = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_winner_reg.sv
// Winner register: holds one granted normal request until software clears it.
// Assumes cand_i is one-hot or zero. The register reloads only while it is empty.
module irq_winner_reg #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cand_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] win_o
);
    // Load a new winner when empty, otherwise only honour clears.
    always_ff @(posedge clk) begin
        if (!rst_n)          win_o <= '0;
        else if (win_o == '0) win_o <= cand_i;
        else                 win_o <= win_o & ~clr_i;
    end
endmodule

// File: rtl/irq_two_stage_ctrl.sv
// Two-stage interrupt controller top.
// Raw pending bits are routed either to the fast line or, if unmasked, to a
// fixed-priority winner register that drives the normal line.
// Assumes NSRC <= BUS_W. Reads are combinational; writes take effect at the edge.
module irq_two_stage_ctrl
    import intc_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NSRC-1:0]     irq_src,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    output logic                irq_n,
    output logic                fiq_n
);
    localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

    logic            wr_en;
    logic [NSRC-1:0] wdat;
    logic [NSRC-1:0] raw_clr, win_clr;
    logic [NSRC-1:0] sp_q, ip_q, mode_q, mask_q;
    logic [NSRC-1:0] cand, cand_grant, ip_onehot_unused;
    logic [IW-1:0]   cand_idx_unused, ip_idx;

    assign wr_en = bus_sel & bus_wr;
    assign wdat  = bus_wdata[NSRC-1:0];

    // Decode the clearing writes for the two pending registers.
    always_comb begin
        raw_clr = (wr_en && bus_addr == OFS_RAW) ? wdat : '0;
        win_clr = (wr_en && bus_addr == OFS_WIN) ? wdat : '0;
    end

    // Routing and mask configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            mask_q <= '1;
        end else if (wr_en) begin
            if (bus_addr == OFS_ROUTE) mode_q <= wdat;
            if (bus_addr == OFS_MASK)  mask_q <= wdat;
        end
    end

    irq_raw_latch #(.N(NSRC)) u_raw (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (irq_src),
        .clr_i  (raw_clr),
        .pend_o (sp_q)
    );

    // Normal-path candidates: pending, routed normal, unmasked.
    assign cand = sp_q & ~mode_q & ~mask_q;

    irq_prio_pick #(.N(NSRC), .IW(IW)) u_pick (
        .req_i   (cand),
        .grant_o (cand_grant),
        .idx_o   (cand_idx_unused)
    );

    irq_winner_reg #(.N(NSRC)) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .cand_i (cand_grant),
        .clr_i  (win_clr),
        .win_o  (ip_q)
    );

    // Encode the held winner; its input is one-hot, so the picker acts as an encoder.
    irq_prio_pick #(.N(NSRC), .IW(IW)) u_enc (
        .req_i   (ip_q),
        .grant_o (ip_onehot_unused),
        .idx_o   (ip_idx)
    );

    // Register read multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            case (bus_addr)
                OFS_RAW:    bus_rdata = BUS_W'(sp_q);
                OFS_ROUTE:  bus_rdata = BUS_W'(mode_q);
                OFS_MASK:   bus_rdata = BUS_W'(mask_q);
                OFS_WIN:    bus_rdata = BUS_W'(ip_q);
                OFS_WINIDX: bus_rdata = BUS_W'(ip_idx);
                default:    bus_rdata = '0;
            endcase
        end
    end

    // Active-low request lines to the processor.
    assign irq_n = ~|ip_q;
    assign fiq_n = ~|(sp_q & mode_q);
endmodule

// File: rtl/irq_two_stage_ctrl_chk.sv
// Property checker for irq_two_stage_ctrl; attached by the bind below.
// Assumes the internal register names of the top module.
module irq_two_stage_ctrl_chk
    import intc_pkg::*;
#(
    parameter int NSRC = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NSRC-1:0]   irq_src,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NSRC-1:0]   sp_q,
    input logic [NSRC-1:0]   ip_q,
    input logic [NSRC-1:0]   mode_q,
    input logic [NSRC-1:0]   mask_q
);
    logic win_clr_wr;
    assign win_clr_wr = bus_sel && bus_wr && (bus_addr == OFS_WIN);

    // R1
    src_sets_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sp_q & $past(irq_src)) == $past(irq_src)));

    // R4
    win_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ip_q));

    // R5
    win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ip_q != '0 && !win_clr_wr) |=> (ip_q == $past(ip_q)));

    // R4
    win_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ip_q != '0 && $past(ip_q) == '0)
        |-> (((ip_q - 1'b1) & $past(sp_q & ~mode_q & ~mask_q)) == '0));

    // R2
    win_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ip_q != '0 && $past(ip_q) == '0) |-> ((ip_q & $past(mode_q)) == '0));

    // R3
    win_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ip_q != '0 && $past(ip_q) == '0) |-> ((ip_q & $past(mask_q)) == '0));
endmodule

bind irq_two_stage_ctrl irq_two_stage_ctrl_chk #(.NSRC(NSRC)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_src (irq_src),
    .bus_sel (bus_sel),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .sp_q    (sp_q),
    .ip_q    (ip_q),
    .mode_q  (mode_q),
    .mask_q  (mask_q)
);

// File: tb/irq_two_stage_ctrl_tb.sv
`timescale 1ns/1ps
// Bench for irq_two_stage_ctrl: directed corner cases, then seeded random traffic,
// all compared against a requirement-level model stepped on the same clock edge.
module irq_two_stage_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_src = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_n, fiq_n;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_sp, m_mode, m_mask, m_ip;

    irq_two_stage_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_n(irq_n), .fiq_n(fiq_n)
    );

    always #2.5 clk = ~clk;

    // Lowest set bit as a one-hot word (bit 0 is highest priority).
    function automatic logic [31:0] lowest(input logic [31:0] v);
        for (int i = 0; i < 32; i++) if (v[i]) return 32'h1 << i;
        return 32'h0;
    endfunction

    function automatic logic [31:0] index_of(input logic [31:0] v);
        for (int i = 0; i < 32; i++) if (v[i]) return i;
        return 32'h0;
    endfunction

    // Requirement-level model, stepped on each rising edge.
    always @(posedge clk) begin : model
        logic [31:0] csp, cip;
        logic        we;
        we  = bus_sel && bus_wr;
        csp = (we && bus_addr == 5'h00) ? bus_wdata : 32'h0;
        cip = (we && bus_addr == 5'h10) ? bus_wdata : 32'h0;
        if (!rst_n) begin
            m_sp <= '0; m_mode <= '0; m_mask <= '1; m_ip <= '0;
        end else begin
            m_sp <= (m_sp & ~csp) | irq_src;
            if (we && bus_addr == 5'h04) m_mode <= bus_wdata;
            if (we && bus_addr == 5'h08) m_mask <= bus_wdata;
            if (m_ip == 0) m_ip <= lowest(m_sp & ~m_mode & ~m_mask);
            else           m_ip <= m_ip & ~cip;
        end
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // One clock: drive at the falling edge, leave 1 ns after the rising edge.
    task automatic step(input logic [31:0] src, input logic w, input logic [4:0] a,
                        input logic [31:0] d);
        @(negedge clk);
        irq_src = src; bus_sel = w; bus_wr = w; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        irq_src = '0; bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #0.1;
        v = bus_rdata;
        bus_sel = 1'b0;
        #0.1;
    endtask

    // Compare every readable register and both pins with the model.
    task automatic check_all(input string tag);
        logic [31:0] v;
        rd(5'h00, v); check({tag, " R1 raw"}, v, m_sp);
        rd(5'h04, v); check({tag, " R2 route"}, v, m_mode);
        rd(5'h08, v); check({tag, " R3 mask"}, v, m_mask);
        rd(5'h10, v); check({tag, " R4 win"}, v, m_ip);
        rd(5'h14, v); check({tag, " R8 idx"}, v, index_of(m_ip));
        check({tag, " R7 irq_n"}, {31'h0, irq_n}, {31'h0, m_ip == 0});
        check({tag, " R2 fiq_n"}, {31'h0, fiq_n}, {31'h0, (m_sp & m_mode) == 0});
    endtask

    initial begin : watchdog
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin : main
        logic [31:0] v;
        void'($urandom(32'h5eed_1c07));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;

        // R9 reset values
        rd(5'h00, v); check("R9 reset raw", v, 32'h0);
        rd(5'h08, v); check("R9 reset mask", v, 32'hFFFF_FFFF);
        rd(5'h10, v); check("R9 reset win", v, 32'h0);
        check("R7 reset irq_n", {31'h0, irq_n}, 32'h1);
        check("R7 reset fiq_n", {31'h0, fiq_n}, 32'h1);

        // R1 / R3: masked source latches but never wins
        step(32'h20, 0, 0, 0);
        rd(5'h00, v); check("R1 raw set", v, 32'h20);
        step(0, 0, 0, 0);
        rd(5'h10, v); check("R3 masked no win", v, 32'h0);
        check("R3 irq_n high", {31'h0, irq_n}, 32'h1);

        // R5 / R7 / R8: unmask, winner appears one edge later
        step(0, 1, 5'h08, 32'h0);
        rd(5'h10, v); check("R5 not yet loaded", v, 32'h0);
        step(0, 0, 0, 0);
        rd(5'h10, v); check("R5 loaded", v, 32'h20);
        rd(5'h14, v); check("R8 index 5", v, 32'd5);
        check("R7 irq_n low", {31'h0, irq_n}, 32'h0);

        // R6: clear raw then winner
        step(0, 1, 5'h00, 32'h20);
        rd(5'h10, v); check("R6 win kept after raw clear", v, 32'h20);
        step(0, 1, 5'h10, 32'h20);
        step(0, 0, 0, 0);
        rd(5'h10, v); check("R6 win cleared", v, 32'h0);
        check("R7 irq_n released", {31'h0, irq_n}, 32'h1);
        rd(5'h14, v); check("R8 index empty", v, 32'h0);

        // R4 / R5: priority, no preemption, reload after clear
        step(32'h88, 0, 0, 0);
        step(0, 0, 0, 0);
        rd(5'h10, v); check("R4 lowest wins", v, 32'h08);
        step(32'h02, 0, 0, 0);
        step(0, 0, 0, 0);
        rd(5'h10, v); check("R5 no preempt", v, 32'h08);
        step(0, 1, 5'h00, 32'h08);
        step(0, 1, 5'h10, 32'h08);
        rd(5'h10, v); check("R5 empty after clear", v, 32'h0);
        step(0, 0, 0, 0);
        rd(5'h10, v); check("R5 reload next", v, 32'h02);
        check_all("directed prio");
        step(0, 1, 5'h00, 32'hFFFF_FFFF);
        step(0, 1, 5'h10, 32'hFFFF_FFFF);
        step(0, 0, 0, 0);

        // R6: zero write keeps, same-cycle set beats clear
        step(32'h200, 0, 0, 0);
        step(0, 1, 5'h00, 32'h0);
        rd(5'h00, v); check("R6 zero write", v, 32'h200);
        step(32'h200, 1, 5'h00, 32'h200);
        rd(5'h00, v); check("R6 set wins", v, 32'h200);
        step(0, 1, 5'h00, 32'h200);
        step(0, 1, 5'h10, 32'hFFFF_FFFF);
        step(0, 0, 0, 0);
        check_all("directed clear");

        // R2: fast routing
        step(0, 1, 5'h04, 32'h10);
        step(32'h10, 0, 0, 0);
        check("R2 fiq_n low", {31'h0, fiq_n}, 32'h0);
        step(0, 0, 0, 0);
        rd(5'h10, v); check("R2 fast not in win", v, 32'h0);
        step(0, 1, 5'h00, 32'h10);
        check("R2 fiq_n released", {31'h0, fiq_n}, 32'h1);

        // R8 / R9: index write ignored, unmapped read is zero
        step(32'h1, 0, 0, 0);
        step(0, 0, 0, 0);
        step(0, 1, 5'h14, 32'h1F);
        rd(5'h14, v); check("R8 index write ignored", v, 32'h0);
        rd(5'h10, v); check("R8 win after index write", v, 32'h1);
        rd(5'h0C, v); check("R9 unmapped", v, 32'h0);
        check_all("directed idx");

        // Seeded random traffic
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] src, d;
            logic [4:0]  a;
            logic        w;
            src = $urandom & $urandom & $urandom & $urandom;
            w   = ($urandom % 2) == 0;
            case ($urandom % 5)
                0: a = 5'h00;
                1: a = 5'h04;
                2: a = 5'h08;
                3: a = 5'h10;
                default: a = 5'h14;
            endcase
            d = $urandom;
            if (($urandom % 2) == 0) d = (a == 5'h10) ? m_ip : m_sp;
            step(src, w, a, d);
            check_all("random");
        end
        finish_run();
    end
endmodule